// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Delayed Request-to-Send Release

This block is the send half of an asynchronous serial channel. Characters arrive through a valid/ready stream into a one-entry holding buffer. A framer moves each character from the buffer into a shift register and puts it on the line. Each frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one high stop bit. Every bit lasts one period of an external bit-time tick. If the buffer already holds the next character when a stop bit ends, that character follows with no idle time between the frames.

A request-to-send output (`rts_n`, active low) follows a control input. When the control input is set, the pin is asserted on the next clock. When the control input is cleared, the pin is not released at once. It is released on the first tick at which the framer is idle and the buffer is empty. After a frame this is one bit time after the tick that ends the last stop bit. A send-break input forces the line low for as long as it is held, whether or not the transmitter is enabled.

Back-pressure on the stream: `in_ready` is high exactly when the buffer is empty. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold its character and `in_valid`. A word offered while `in_ready` is low is not taken and does not change the buffer.

Top module: `serial_tx_rts`

## Requirements
- R1: After reset, `txd` is 1, `rts_n` is 1, `buf_empty` is 1 and `in_ready` is 1.
- R2: `in_ready` equals `buf_empty`. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `buf_empty` is 0 on the next cycle. While the buffer is full, offered words are ignored, and the held word is the one that is later sent.
- R3: A frame is sent on `txd` in this order: a start bit of 0, then the data bits least significant first, then the parity bit if enabled, then a stop bit of 1. The number of data bits is 5 + `char_len`, so 00 gives 5 bits and 11 gives 8 bits. Bits of `in_data` above that length are not sent. `txd` changes only after a clock edge where `bit_tick` is 1.
- R4: When `par_en` is 1, a parity bit is sent after the data bits. With `par_odd` = 0 the count of ones over data and parity is even; with `par_odd` = 1 it is odd. The format inputs are sampled when a character leaves the buffer.
- R5: If the buffer is full and `tx_en` is 1 at the tick that ends a stop bit, the next start bit begins on that same tick, so there is no idle bit between the frames.
- R6: A character leaves the buffer only on a tick where `tx_en` is 1. Clearing `tx_en` lets the current frame complete. After that, `txd` stays at 1 and a held character stays in the buffer.
- R7: While `brk_cmd` is 1, `txd` is 0 in the same cycle, whatever `tx_en` is set to. When `brk_cmd` returns to 0, the line goes back to its framed value.
- R8: When `rts_ctl` is 1, `rts_n` is 0 from the next clock edge.
- R9: With `rts_ctl` at 0, `rts_n` rises on a tick edge at which the framer is idle and the buffer is empty. After a frame, this is the tick that follows the tick ending the stop bit, so `rts_n` is still 0 just after the stop-ending tick and 1 just after the next tick.
- R10: While a character waits in the buffer, `rts_n` stays 0 even with `rts_ctl` at 0 and the framer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Allows a new frame to start |
| rts_ctl | input | 1 | Request-to-send control bit, 1 = assert |
| brk_cmd | input | 1 | Send-break command, forces the line low |
| bit_tick | input | 1 | One-clock pulse per bit time |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Buffer can take a word |
| in_data | input | 8 | Stream word (character) |
| txd | output | 1 | Serial line, 1 = marking |
| rts_n | output | 1 | Request-to-send pin, active low |
| buf_empty | output | 1 | Holding buffer is empty |

## Verification
Each line bit appears one clock after the tick edge that starts it. The bench waits for a rising clock edge where `bit_tick` is high and reads `txd` at the next falling edge, so it reads each bit once, in the middle of its bit period. The break response is combinational, so it is read at the first falling edge after `brk_cmd` changes. The request-to-send assertion is read one full clock after `rts_ctl` is set. The release is read on tick boundaries: just after the tick that ends the stop bit, where `rts_n` must still be 0, and just after the following tick, where it must be 1. Stream acceptance is read at the falling edge after the accepting rising edge.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/tx_holdbuf.sv
module tx_holdbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic [W-1:0] out_data,
  output logic         full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
    end else if (in_valid && !full) begin
      full     <= 1'b1;
      out_data <= in_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  assign in_ready = !full;
endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import ser_tx_pkg::*;
#(
  parameter int W        = 8,
  parameter int LEN_W    = 2,
  parameter int MIN_BITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_en,
  input  logic             have_data,
  input  logic [W-1:0]     data,
  input  logic [LEN_W-1:0] char_len,
  input  logic             par_en,
  input  logic             par_odd,
  output logic             pop,
  output logic             line,
  output logic             idle
);
  localparam int CNT_W = $clog2(W);

  tx_state_e        st;
  logic [W-1:0]     sh;
  logic [CNT_W-1:0] cnt, last, len_new;
  logic             par_q, par_en_q, par_calc, launch;

  assign len_new = CNT_W'(MIN_BITS - 1) + CNT_W'(char_len);

  always_comb begin
    par_calc = par_odd;
    for (int i = 0; i < W; i++) begin
      if (CNT_W'(i) <= len_new) par_calc = par_calc ^ data[i];
    end
  end

  // a frame may start from idle or straight out of a stop bit
  assign launch = bit_tick && have_data && tx_en &&
                  (st == ST_IDLE || st == ST_STOP);
  assign pop    = launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sh       <= '0;
      cnt      <= '0;
      last     <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
    end else if (launch) begin
      st       <= ST_START;
      sh       <= data;
      cnt      <= '0;
      last     <= len_new;
      par_q    <= par_calc;
      par_en_q <= par_en;
    end else if (bit_tick) begin
      case (st)
        ST_START: st <= ST_DATA;
        ST_DATA: begin
          if (cnt == last) begin
            st <= par_en_q ? ST_PAR : ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
            sh  <= sh >> 1;
          end
        end
        ST_PAR:  st <= ST_STOP;
        ST_STOP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign idle = (st == ST_IDLE);
endmodule

// File: rtl/tx_rts_ctrl.sv
module tx_rts_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rts_ctl,
  input  logic line_idle,
  input  logic buf_empty,
  output logic rts_n
);
  // the framer reaches idle on the stop-ending tick, so the
  // earliest release is the tick after: one bit time later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  rts_n <= 1'b1;
    else if (rts_ctl)                            rts_n <= 1'b0;
    else if (bit_tick && line_idle && buf_empty) rts_n <= 1'b1;
  end
endmodule

// File: rtl/serial_tx_rts.sv
module serial_tx_rts #(
  parameter int W        = 8,
  parameter int LEN_W    = 2,
  parameter int MIN_BITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rts_ctl,
  input  logic             brk_cmd,
  input  logic             bit_tick,
  input  logic [LEN_W-1:0] char_len,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             txd,
  output logic             rts_n,
  output logic             buf_empty
);
  logic         full, pop, line, idle;
  logic [W-1:0] held;

  tx_holdbuf #(.W(W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pop(pop), .out_data(held), .full(full)
  );

  tx_framer #(.W(W), .LEN_W(LEN_W), .MIN_BITS(MIN_BITS)) u_frm (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .have_data(full), .data(held), .char_len(char_len), .par_en(par_en),
    .par_odd(par_odd), .pop(pop), .line(line), .idle(idle)
  );

  tx_rts_ctrl u_rts (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rts_ctl(rts_ctl),
    .line_idle(idle), .buf_empty(!full), .rts_n(rts_n)
  );

  assign buf_empty = !full;
  assign txd       = line && !brk_cmd;
endmodule

// File: rtl/tx_rts_checker.sv
module tx_rts_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rts_ctl,
  input logic brk_cmd,
  input logic bit_tick,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic rts_n,
  input logic buf_empty
);
  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !buf_empty);

  p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_tick) && !brk_cmd && !$past(brk_cmd)) |-> $stable(txd));

  p_held_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !buf_empty) |=> !buf_empty);

  p_break_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_cmd |-> !txd);

  p_rts_assert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rts_ctl |=> !rts_n);

  p_rts_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> ($past(bit_tick) && !$past(rts_ctl)));

  p_rts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> buf_empty);
endmodule

bind serial_tx_rts tx_rts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rts_ctl(rts_ctl),
  .brk_cmd(brk_cmd), .bit_tick(bit_tick), .in_valid(in_valid),
  .in_ready(in_ready), .txd(txd), .rts_n(rts_n), .buf_empty(buf_empty)
);

// File: tb/serial_tx_rts_bench.sv
module serial_tx_rts_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tx_en = 1'b0, rts_ctl = 1'b0, brk_cmd = 1'b0, bit_tick = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, txd, rts_n, buf_empty;
  int         nvec = 0, nerr = 0, tcnt = 0;
  bit         done = 1'b0;

  serial_tx_rts u_serial_tx_rts (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rts_ctl(rts_ctl),
    .brk_cmd(brk_cmd), .bit_tick(bit_tick), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .txd(txd), .rts_n(rts_n),
    .buf_empty(buf_empty)
  );

  always #2 clk = ~clk;

  // one tick every four clocks, changed on falling edges
  always @(negedge clk) begin
    tcnt     = (tcnt + 1) % 4;
    bit_tick = (tcnt == 0);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // rising edge with a tick, then the falling edge after it
  task automatic next_bit();
    do @(posedge clk); while (!bit_tick);
    @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    do @(posedge clk); while (!in_ready);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get_frame(string tag, int nbits, bit pen, bit podd,
                           logic [7:0] d, bit immediate, bit drop_en);
    logic p;
    int   guard = 0;
    next_bit();
    if (immediate) chk({tag, " R5 start with no gap"}, txd, 0);
    else while (txd !== 1'b0 && guard < 60) begin next_bit(); guard++; end
    chk({tag, " R3 start bit"}, txd, 0);
    if (drop_en) tx_en = 1'b0;
    p = podd;
    for (int i = 0; i < nbits; i++) begin
      next_bit();
      chk({tag, " R3 data bit"}, txd, d[i]);
      p ^= d[i];
    end
    if (pen) begin
      next_bit();
      chk({tag, " R4 parity bit"}, txd, p);
    end
    next_bit();
    chk({tag, " R3 stop bit"}, txd, 1);
  endtask

  task automatic sc_reset();
    chk("R1 txd", txd, 1);
    chk("R1 rts_n", rts_n, 1);
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic sc_format(logic [1:0] cl, bit pen, bit podd, logic [7:0] d);
    char_len = cl; par_en = pen; par_odd = podd; tx_en = 1'b1;
    send_byte(d);
    get_frame("fmt", 5 + int'(cl), pen, podd, d, 0, 0);
    next_bit();
    chk("R3 idle after frame", txd, 1);
  endtask

  task automatic sc_buffer();
    tx_en = 1'b0; char_len = 2'd3; par_en = 1'b0;
    send_byte(8'h3C);
    chk("R2 buffer full", buf_empty, 0);
    chk("R2 not ready", in_ready, 0);
    @(negedge clk); in_valid = 1'b1; in_data = 8'hFF;
    repeat (3) next_bit();
    in_valid = 1'b0;
    chk("R2 still full", buf_empty, 0);
    tx_en = 1'b1;
    get_frame("R2 held word", 8, 0, 0, 8'h3C, 0, 0);
  endtask

  task automatic sc_b2b();
    tx_en = 1'b1; char_len = 2'd2; par_en = 1'b1; par_odd = 1'b0;
    send_byte(8'h55);
    fork
      get_frame("R5 first", 7, 1, 0, 8'h55, 0, 0);
      begin
        do @(negedge clk); while (!buf_empty);
        send_byte(8'h0E);
      end
    join
    get_frame("R5 second", 7, 1, 0, 8'h0E, 1, 0);
  endtask

  task automatic sc_disable();
    tx_en = 1'b1; char_len = 2'd3; par_en = 1'b0;
    send_byte(8'hC3);
    fork
      get_frame("R6 finish", 8, 0, 0, 8'hC3, 0, 1);
      begin
        do @(negedge clk); while (!buf_empty);
        send_byte(8'h81);
      end
    join
    for (int i = 0; i < 6; i++) begin
      next_bit();
      chk("R6 line idle while off", txd, 1);
    end
    chk("R6 word kept", buf_empty, 0);
    tx_en = 1'b1;
    get_frame("R6 drain", 8, 0, 0, 8'h81, 0, 0);
  endtask

  task automatic sc_break();
    tx_en = 1'b0; brk_cmd = 1'b1;
    @(negedge clk);
    chk("R7 break while disabled", txd, 0);
    repeat (2) next_bit();
    chk("R7 break held", txd, 0);
    brk_cmd = 1'b0;
    @(negedge clk);
    chk("R7 break released", txd, 1);
  endtask

  task automatic sc_rts();
    rts_ctl = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 rts asserted", rts_n, 0);
    tx_en = 1'b1; char_len = 2'd0; par_en = 1'b1; par_odd = 1'b1;
    send_byte(8'hF6);
    rts_ctl = 1'b0;
    get_frame("R9 frame", 5, 1, 1, 8'hF6, 0, 0);
    chk("R9 low during stop", rts_n, 0);
    next_bit();
    chk("R9 low after stop-ending tick", rts_n, 0);
    next_bit();
    chk("R9 released one bit later", rts_n, 1);
  endtask

  task automatic sc_rts_pending();
    rts_ctl = 1'b1; tx_en = 1'b0; char_len = 2'd3; par_en = 1'b0;
    @(posedge clk);
    send_byte(8'h96);
    rts_ctl = 1'b0;
    for (int i = 0; i < 4; i++) begin
      next_bit();
      chk("R10 rts held with word waiting", rts_n, 0);
    end
    tx_en = 1'b1;
    get_frame("R10 frame", 8, 0, 0, 8'h96, 0, 0);
    next_bit();
    chk("R10 low at stop end", rts_n, 0);
    next_bit();
    chk("R10 released", rts_n, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    sc_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    sc_format(2'd3, 0, 0, 8'hA5);
    sc_format(2'd0, 1, 0, 8'hF3);
    sc_format(2'd2, 1, 1, 8'h5A);
    sc_format(2'd1, 1, 0, 8'h2B);
    sc_buffer();
    sc_b2b();
    sc_disable();
    sc_break();
    sc_rts();
    sc_rts_pending();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule